// File: doc/BRIEF.md
# Event Timer Main Counter and Register File

This block is the global core of a multi-channel event timer. It holds a 64-bit free-running main counter, a small global configuration register, a read-only capability word and the per-channel configuration, comparator and message-route registers. Software reaches all of it through a 32-bit register bus. Each access is one word wide, so every 64-bit register is exposed as two words, the low half first and the high half four bytes above it.

The counter advances by one on each cycle where the tick strobe is high and the global run bit is set. Clearing the run bit freezes the counter, and setting it again resumes counting from the frozen value. Channel registers sit in fixed-stride windows above the global area. The block drives the channel-side logic (match, interrupt delivery) through flat register outputs and single-cycle pulses. These pulses mark a comparator write, arming on a run-bit rise, disarming on a run-bit fall, and the clearing of pending status bits.

The number of implemented channels is the `NUM_CH` parameter clamped to the range 3 to `MAX_CH`. Channel windows above that count read as zero and ignore writes.

Top module: `hpt_regfile`

## Requirements
- R1: Every access is 32 bits. A 64-bit register is read and written as two words: bits 31:0 at the register offset and bits 63:32 at offset +4. The counter sits at 0x0F0/0x0F4.
- R2: Reset clears the counter and global config. The counter increases by exactly one per tick strobe while the run bit is set and holds its value while the run bit is clear, resuming from the held value when the run bit is set again.
- R3: Either counter half may be written whether running or not. The written half takes the written value, and a write overrides a tick increment in the same cycle.
- R4: The capability word at 0x000 is read-only. Bits 7:0 read 0x01, bits 12:8 read the channel count minus one, bit 13 (64-bit counter) and bit 15 (legacy route capable) read 1, and the rest read 0. Offset 0x004 reads the tick period in femtoseconds.
- R5: Global config at 0x010 holds the run bit (bit 0, output `run_o`) and the legacy-route bit (bit 1, output `legacy_o`). All other bits read zero, and 0x014 reads zero.
- R6: Channel n has its window at 0x100 + 0x20*n, holding config at +0x00, comparator at +0x08 and message route at +0x10. After reset, config reads 0x30, the comparator reads all ones and the route reads zero.
- R7: In channel config, only the bits in mask 0x7F4E take the written value. Bits 4 and 5 always read 1, other bits read 0, and the upper word reads the `ROUTE_CAP` parameter and ignores writes.
- R8: The channel count is NUM_CH clamped to [3, MAX_CH]. Windows at or above that count read zero and ignore writes, and no per-channel output for such an index ever changes.
- R9: A config write that sets the run bit while it is clear gives, in the next cycle, a one-cycle `ch_arm_o` pulse for every implemented channel whose comparator is not all ones.
- R10: A config write that clears the run bit while it is set gives, in the next cycle, a one-cycle pulse on `ch_disarm_o` and on `status_clr_o` for every implemented channel.
- R11: Offset 0x020 reads `irq_status_i` limited to implemented channels, and 0x024 reads zero. Writing 0x020 gives a one-cycle `status_clr_o` pulse on the bits that are both written as 1 and pending.
- R12: A write to either comparator half of channel n gives a one-cycle pulse on bit n of `ch_cmp_wr_o`. The pulse comes in the cycle the new value first appears on `ch_cmp_o`.
- R13: Unmapped or unaligned offsets read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter increment strobe |
| bus_addr_i | input | 10 | Byte offset of the access |
| bus_wr_i | input | 1 | Write strobe for this cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_status_i | input | MAX_CH | Pending interrupt flags from the channels |
| count_o | output | 64 | Main counter value |
| run_o | output | 1 | Global run bit |
| legacy_o | output | 1 | Legacy-route bit |
| ch_cfg_o | output | MAX_CH*32 | Channel config low words, channel n at bits 32n+31:32n |
| ch_cmp_o | output | MAX_CH*64 | Channel comparators |
| ch_route_o | output | MAX_CH*64 | Channel message-route values |
| ch_cmp_wr_o | output | MAX_CH | Comparator-written pulses |
| ch_arm_o | output | MAX_CH | Arm pulses on run rise |
| ch_disarm_o | output | MAX_CH | Disarm pulses on run fall |
| status_clr_o | output | MAX_CH | Pending-status clear pulses |

## Verification
The assertions check the following on every cycle:
- the counter either holds or steps by one according to the run bit and tick strobe, unless a counter write lands;
- arm and disarm pulses occur only on a real rise or fall of the run bit;
- no pulse ever appears on an unimplemented channel index;
- comparator-write pulses are one-hot;
- the capability flags and the zero upper config word read correctly.

Only the bench scenarios can show the rest:
- the write masks on channel config;
- the window stride and the split-word read-back;
- freeze-and-resume counting across several toggles;
- arming only the channels whose comparator was changed from all ones;
- the clamping of a too-small channel count.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    // decoded register field of one 32-bit access
    typedef enum logic [3:0] {
        F_NONE,
        F_CAP_LO,  F_CAP_HI,
        F_GCFG_LO, F_GCFG_HI,
        F_STAT_LO, F_STAT_HI,
        F_CNT_LO,  F_CNT_HI,
        F_CCFG_LO, F_CCFG_HI,
        F_CCMP_LO, F_CCMP_HI,
        F_CRT_LO,  F_CRT_HI
    } fld_e;

    localparam logic [9:0] OFS_CAP     = 10'h000;
    localparam logic [9:0] OFS_GCFG    = 10'h010;
    localparam logic [9:0] OFS_STAT    = 10'h020;
    localparam logic [9:0] OFS_CNT     = 10'h0F0;
    localparam logic [9:0] OFS_CH_BASE = 10'h100;
    localparam int         CH_STRIDE_LG = 5;

    localparam logic [31:0] CCFG_WMASK = 32'h0000_7F4E;
    localparam logic [31:0] CCFG_FIXED = 32'h0000_0030;
    localparam logic [31:0] CAP_BASE   = 32'h0000_A001;

    function automatic int clamp_ch(input int req, input int max_ch);
        int r;
        r = (req < 3) ? 3 : req;
        return (r > max_ch) ? max_ch : r;
    endfunction

endpackage

// File: rtl/hpt_addr_decode.sv
module hpt_addr_decode
    import hpt_pkg::*;
#(
    parameter  int MAX_CH = 8,
    parameter  int CH     = 3,
    localparam int IW     = $clog2(MAX_CH)
) (
    input  logic [9:0]    addr_i,
    output fld_e          fld_o,
    output logic [IW-1:0] ch_idx_o
);

    logic [9:0] rel;

    always_comb begin
        rel      = addr_i - OFS_CH_BASE;
        fld_o    = F_NONE;
        ch_idx_o = '0;
        if (addr_i < OFS_CH_BASE) begin
            case (addr_i)
                OFS_CAP:          fld_o = F_CAP_LO;
                OFS_CAP + 10'h4:  fld_o = F_CAP_HI;
                OFS_GCFG:         fld_o = F_GCFG_LO;
                OFS_GCFG + 10'h4: fld_o = F_GCFG_HI;
                OFS_STAT:         fld_o = F_STAT_LO;
                OFS_STAT + 10'h4: fld_o = F_STAT_HI;
                OFS_CNT:          fld_o = F_CNT_LO;
                OFS_CNT + 10'h4:  fld_o = F_CNT_HI;
                default:          fld_o = F_NONE;
            endcase
        end else if (int'(rel[9:CH_STRIDE_LG]) < CH) begin
            ch_idx_o = rel[CH_STRIDE_LG +: IW];
            case (rel[CH_STRIDE_LG-1:0])
                5'h00:   fld_o = F_CCFG_LO;
                5'h04:   fld_o = F_CCFG_HI;
                5'h08:   fld_o = F_CCMP_LO;
                5'h0C:   fld_o = F_CCMP_HI;
                5'h10:   fld_o = F_CRT_LO;
                5'h14:   fld_o = F_CRT_HI;
                default: fld_o = F_NONE;
            endcase
        end
    end

endmodule

// File: rtl/hpt_chan_regs.sv
module hpt_chan_regs
    import hpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_cfg_i,
    input  logic        we_cmp_lo_i,
    input  logic        we_cmp_hi_i,
    input  logic        we_rt_lo_i,
    input  logic        we_rt_hi_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] cfg_o,
    output logic [63:0] cmp_o,
    output logic [63:0] route_o
);

    typedef struct packed {
        logic [31:0] cfg;
        logic [63:0] cmp;
        logic [63:0] rt;
    } chan_st_t;

    localparam chan_st_t RST_ST = '{cfg: CCFG_FIXED, cmp: '1, rt: '0};

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_cfg_i)    st_d.cfg        = (wdata_i & CCFG_WMASK) | CCFG_FIXED;
        if (we_cmp_lo_i) st_d.cmp[31:0]  = wdata_i;
        if (we_cmp_hi_i) st_d.cmp[63:32] = wdata_i;
        if (we_rt_lo_i)  st_d.rt[31:0]   = wdata_i;
        if (we_rt_hi_i)  st_d.rt[63:32]  = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign cfg_o   = st_q.cfg;
    assign cmp_o   = st_q.cmp;
    assign route_o = st_q.rt;

endmodule

// File: rtl/hpt_regfile.sv
module hpt_regfile
    import hpt_pkg::*;
#(
    parameter int          MAX_CH    = 8,
    parameter int          NUM_CH    = 4,
    parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [9:0]           bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    input  logic [MAX_CH-1:0]    irq_status_i,
    output logic [63:0]          count_o,
    output logic                 run_o,
    output logic                 legacy_o,
    output logic [MAX_CH*32-1:0] ch_cfg_o,
    output logic [MAX_CH*64-1:0] ch_cmp_o,
    output logic [MAX_CH*64-1:0] ch_route_o,
    output logic [MAX_CH-1:0]    ch_cmp_wr_o,
    output logic [MAX_CH-1:0]    ch_arm_o,
    output logic [MAX_CH-1:0]    ch_disarm_o,
    output logic [MAX_CH-1:0]    status_clr_o
);

    localparam int CH = clamp_ch(NUM_CH, MAX_CH);
    localparam int IW = $clog2(MAX_CH);
    localparam logic [MAX_CH-1:0] VALID  = MAX_CH'((64'd1 << CH) - 64'd1);
    localparam logic [31:0]       CAP_LO = CAP_BASE | (32'(CH - 1) << 8);

    typedef struct packed {
        logic [63:0]       cnt;
        logic              run;
        logic              legacy;
        logic [MAX_CH-1:0] arm;
        logic [MAX_CH-1:0] disarm;
        logic [MAX_CH-1:0] clr;
        logic [MAX_CH-1:0] cmpwr;
    } glb_st_t;

    glb_st_t st_d, st_q;

    fld_e          fld, wr_fld;
    logic [IW-1:0] ch_idx;

    logic [MAX_CH-1:0][31:0] cfg_a;
    logic [MAX_CH-1:0][63:0] cmp_a;
    logic [MAX_CH-1:0][63:0] rt_a;

    hpt_addr_decode #(.MAX_CH(MAX_CH), .CH(CH)) u_dec (
        .addr_i   (bus_addr_i),
        .fld_o    (fld),
        .ch_idx_o (ch_idx)
    );

    assign wr_fld = bus_wr_i ? fld : F_NONE;

    for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
        if (g < CH) begin : g_impl
            logic sel;
            assign sel = (ch_idx == IW'(g));
            hpt_chan_regs u_regs (
                .clk         (clk),
                .rst_n       (rst_n),
                .we_cfg_i    (sel && wr_fld == F_CCFG_LO),
                .we_cmp_lo_i (sel && wr_fld == F_CCMP_LO),
                .we_cmp_hi_i (sel && wr_fld == F_CCMP_HI),
                .we_rt_lo_i  (sel && wr_fld == F_CRT_LO),
                .we_rt_hi_i  (sel && wr_fld == F_CRT_HI),
                .wdata_i     (bus_wdata_i),
                .cfg_o       (cfg_a[g]),
                .cmp_o       (cmp_a[g]),
                .route_o     (rt_a[g])
            );
        end else begin : g_absent
            assign cfg_a[g] = '0;
            assign cmp_a[g] = '0;
            assign rt_a[g]  = '0;
        end
    end

    // next-state of counter, global config and channel-side pulses
    always_comb begin
        st_d        = st_q;
        st_d.arm    = '0;
        st_d.disarm = '0;
        st_d.clr    = '0;
        st_d.cmpwr  = '0;
        if (st_q.run && tick_i) st_d.cnt = st_q.cnt + 64'd1;
        case (wr_fld)
            F_CNT_LO: st_d.cnt = {st_q.cnt[63:32], bus_wdata_i};
            F_CNT_HI: st_d.cnt = {bus_wdata_i, st_q.cnt[31:0]};
            F_GCFG_LO: begin
                st_d.run    = bus_wdata_i[0];
                st_d.legacy = bus_wdata_i[1];
                if (bus_wdata_i[0] && !st_q.run) begin
                    for (int i = 0; i < MAX_CH; i++)
                        st_d.arm[i] = VALID[i] && (cmp_a[i] != '1);
                end
                if (!bus_wdata_i[0] && st_q.run) begin
                    st_d.disarm = VALID;
                    st_d.clr    = VALID;
                end
            end
            F_STAT_LO: st_d.clr = bus_wdata_i[MAX_CH-1:0] & irq_status_i & VALID;
            F_CCMP_LO, F_CCMP_HI: st_d.cmpwr[ch_idx] = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        case (fld)
            F_CAP_LO:  bus_rdata_o = CAP_LO;
            F_CAP_HI:  bus_rdata_o = PERIOD_FS;
            F_GCFG_LO: bus_rdata_o = {30'b0, st_q.legacy, st_q.run};
            F_STAT_LO: bus_rdata_o = 32'(irq_status_i & VALID);
            F_CNT_LO:  bus_rdata_o = st_q.cnt[31:0];
            F_CNT_HI:  bus_rdata_o = st_q.cnt[63:32];
            F_CCFG_LO: bus_rdata_o = cfg_a[ch_idx];
            F_CCFG_HI: bus_rdata_o = ROUTE_CAP;
            F_CCMP_LO: bus_rdata_o = cmp_a[ch_idx][31:0];
            F_CCMP_HI: bus_rdata_o = cmp_a[ch_idx][63:32];
            F_CRT_LO:  bus_rdata_o = rt_a[ch_idx][31:0];
            F_CRT_HI:  bus_rdata_o = rt_a[ch_idx][63:32];
            default:   bus_rdata_o = '0;
        endcase
    end

    assign count_o      = st_q.cnt;
    assign run_o        = st_q.run;
    assign legacy_o     = st_q.legacy;
    assign ch_cfg_o     = cfg_a;
    assign ch_cmp_o     = cmp_a;
    assign ch_route_o   = rt_a;
    assign ch_cmp_wr_o  = st_q.cmpwr;
    assign ch_arm_o     = st_q.arm;
    assign ch_disarm_o  = st_q.disarm;
    assign status_clr_o = st_q.clr;

endmodule

// File: rtl/hpt_regfile_chk.sv
module hpt_regfile_chk
    import hpt_pkg::*;
#(
    parameter int MAX_CH = 8,
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [9:0]        bus_addr_i,
    input logic              bus_wr_i,
    input logic [31:0]       bus_wdata_i,
    input logic [31:0]       bus_rdata_o,
    input logic [63:0]       count_o,
    input logic              run_o,
    input logic [MAX_CH-1:0] ch_cmp_wr_o,
    input logic [MAX_CH-1:0] ch_arm_o,
    input logic [MAX_CH-1:0] ch_disarm_o,
    input logic [MAX_CH-1:0] status_clr_o
);

    localparam int CH = clamp_ch(NUM_CH, MAX_CH);
    localparam logic [MAX_CH-1:0] VALID = MAX_CH'((64'd1 << CH) - 64'd1);

    logic cnt_wr;
    assign cnt_wr = bus_wr_i && (bus_addr_i == OFS_CNT || bus_addr_i == OFS_CNT + 10'h4);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !cnt_wr) |=> $stable(count_o)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && tick_i && !cnt_wr) |=> (count_o == $past(count_o) + 64'd1)); // R2
    AST_CNT_WR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFS_CNT) |=> (count_o[31:0] == $past(bus_wdata_i))); // R3
    AST_CAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == OFS_CAP) |-> (bus_rdata_o[13] && bus_rdata_o[15])); // R4
    AST_GCFG_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == OFS_GCFG + 10'h4) |-> (bus_rdata_o == 32'h0)); // R5
    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_arm_o | ch_disarm_o | status_clr_o | ch_cmp_wr_o) & ~VALID) == '0); // R8
    AST_ARM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_arm_o) |-> (run_o && !$past(run_o))); // R9
    AST_DISARM_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_disarm_o) |-> (!run_o && $past(run_o) && status_clr_o == ch_disarm_o)); // R10
    AST_CMPWR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_cmp_wr_o)); // R12

endmodule

bind hpt_regfile hpt_regfile_chk #(.MAX_CH(MAX_CH), .NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wr_i     (bus_wr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .count_o      (count_o),
    .run_o        (run_o),
    .ch_cmp_wr_o  (ch_cmp_wr_o),
    .ch_arm_o     (ch_arm_o),
    .ch_disarm_o  (ch_disarm_o),
    .status_clr_o (status_clr_o)
);

// File: tb/test_hpt_regfile.sv
module test_hpt_regfile;

    localparam int MAX_CH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [9:0]        addr = '0;
    logic              wr = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata, rdata_s;
    logic [MAX_CH-1:0] irq = '0;
    logic [63:0]       count, count_s;
    logic              run, legacy, run_s, legacy_s;
    logic [MAX_CH*32-1:0] cfg_v, cfg_s;
    logic [MAX_CH*64-1:0] cmp_v, rt_v, cmp_s, rt_s;
    logic [MAX_CH-1:0] cmpwr, arm, disarm, clr, cmpwr_s, arm_s, disarm_s, clr_s;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hpt_regfile i_hpt_regfile (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_status_i(irq), .count_o(count),
        .run_o(run), .legacy_o(legacy), .ch_cfg_o(cfg_v), .ch_cmp_o(cmp_v),
        .ch_route_o(rt_v), .ch_cmp_wr_o(cmpwr), .ch_arm_o(arm), .ch_disarm_o(disarm),
        .status_clr_o(clr)
    );

    // requested count below the minimum, clamped to 3
    hpt_regfile #(.NUM_CH(2)) i_hpt_regfile_small (
        .clk(clk), .rst_n(rst_n), .tick_i(1'b0), .bus_addr_i(addr), .bus_wr_i(1'b0),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata_s), .irq_status_i(irq), .count_o(count_s),
        .run_o(run_s), .legacy_o(legacy_s), .ch_cfg_o(cfg_s), .ch_cmp_o(cmp_s),
        .ch_route_o(rt_s), .ch_cmp_wr_o(cmpwr_s), .ch_arm_o(arm_s), .ch_disarm_o(disarm_s),
        .status_clr_o(clr_s)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int k);
        @(negedge clk);
        tick = 1'b1;
        repeat (k) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R2 reset counter", count, 64'h0);
        chk("R5 reset run", {63'b0, run}, 64'h0);
        bus_read(10'h108, d);
        chk("R6 reset comparator lo", d, 32'hFFFF_FFFF);
        bus_read(10'h110, d);
        chk("R6 reset route lo", d, 32'h0);
    endtask

    task automatic t_capability();
        logic [31:0] d;
        bus_read(10'h000, d);
        chk("R4 capability low", d, 32'h0000_A301);
        chk("R8 clamped count in capability", rdata_s, 32'h0000_A201);
        bus_read(10'h004, d);
        chk("R4 period", d, 32'd10_000_000);
        bus_write(10'h000, 32'h0);
        bus_read(10'h000, d);
        chk("R4 capability ignores write", d, 32'h0000_A301);
    endtask

    task automatic t_gcfg();
        logic [31:0] d;
        bus_write(10'h010, 32'hFFFF_FFFE);
        bus_read(10'h010, d);
        chk("R5 only legacy bit kept", d, 32'h2);
        chk("R5 legacy output", {run, legacy}, 2'b01);
        bus_read(10'h014, d);
        chk("R5 upper config word", d, 32'h0);
        bus_write(10'h010, 32'h0);
        bus_write(10'h030, 32'hFFFF_FFFF);
        bus_read(10'h030, d);
        chk("R13 unmapped read", d, 32'h0);
        chk("R13 unmapped write no effect", {count, 62'b0, run, legacy}, 128'h0);
        bus_read(10'h11C, d);
        chk("R13 unmapped channel slot", d, 32'h0);
        bus_read(10'h012, d);
        chk("R13 unaligned offset", d, 32'h0);
    endtask

    task automatic t_arm();
        bus_write(10'h128, 32'h0000_0100);
        chk("R12 comparator write pulse", cmpwr, 8'h02);
        chk("R12 comparator value visible", cmp_v[64 +: 64], 64'hFFFF_FFFF_0000_0100);
        @(negedge clk);
        chk("R12 pulse lasts one cycle", cmpwr, 8'h00);
        bus_write(10'h010, 32'h1);
        chk("R9 arm only changed comparator", arm, 8'h02);
        @(negedge clk);
        chk("R9 arm one cycle", arm, 8'h00);
        bus_write(10'h010, 32'h1);
        chk("R9 no arm when already running", arm, 8'h00);
        bus_write(10'h010, 32'h0);
        chk("R10 disarm all channels", disarm, 8'h0F);
        chk("R10 clear all pending", clr, 8'h0F);
        @(negedge clk);
        chk("R10 pulses one cycle", {disarm, clr}, 16'h0);
    endtask

    task automatic t_counter_run();
        logic [31:0] d;
        ticks(4);
        chk("R2 hold while stopped", count, 64'h0);
        bus_write(10'h010, 32'h1);
        ticks(5);
        bus_read(10'h0F0, d);
        chk("R2 counted five ticks", d, 32'd5);
        bus_write(10'h010, 32'h0);
        ticks(6);
        bus_read(10'h0F0, d);
        chk("R2 frozen after stop", d, 32'd5);
        bus_write(10'h010, 32'h1);
        ticks(2);
        bus_write(10'h010, 32'h0);
        chk("R2 resume from held value", count, 64'd7);
    endtask

    task automatic t_counter_write();
        logic [31:0] d;
        bus_write(10'h0F0, 32'hFFFF_FFFE);
        bus_write(10'h0F4, 32'h0000_0001);
        bus_read(10'h0F4, d);
        chk("R1 counter high half", d, 32'h1);
        bus_read(10'h0F0, d);
        chk("R1 counter low half", d, 32'hFFFF_FFFE);
        bus_write(10'h010, 32'h1);
        ticks(3);
        chk("R2 carry into high half", count, 64'h2_0000_0001);
        @(negedge clk);
        addr = 10'h0F0; wdata = 32'h100; wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        chk("R3 write while running overrides tick", count, 64'h2_0000_0100);
        bus_write(10'h010, 32'h0);
    endtask

    task automatic t_chan_regs();
        logic [31:0] d;
        bus_read(10'h140, d);
        chk("R6 channel config reset", d, 32'h30);
        bus_write(10'h140, 32'hFFFF_FFFF);
        bus_read(10'h140, d);
        chk("R7 config mask", d, 32'h7F7E);
        chk("R7 config output", cfg_v[64 +: 32], 32'h7F7E);
        bus_write(10'h140, 32'h0);
        bus_read(10'h140, d);
        chk("R7 capability bits fixed", d, 32'h30);
        bus_write(10'h144, 32'h0);
        bus_read(10'h144, d);
        chk("R7 upper config read-only", d, 32'h00F0_0000);
        bus_write(10'h148, 32'hAAAA_5555);
        bus_write(10'h14C, 32'h1234_5678);
        chk("R1 comparator split write", cmp_v[128 +: 64], 64'h1234_5678_AAAA_5555);
        bus_read(10'h14C, d);
        chk("R6 comparator high read", d, 32'h1234_5678);
        bus_write(10'h170, 32'hCAFE_0001);
        bus_write(10'h174, 32'h0000_BEEF);
        chk("R6 route of channel 3", rt_v[192 +: 64], 64'h0000_BEEF_CAFE_0001);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        bus_write(10'h188, 32'h55);
        chk("R8 no pulse for absent channel", cmpwr, 8'h00);
        bus_read(10'h188, d);
        chk("R8 absent channel reads zero", d, 32'h0);
        chk("R8 absent channel output", cmp_v[256 +: 64], 64'h0);
        bus_read(10'h3E0, d);
        chk("R8 last window reads zero", d, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        irq = 8'hFF;
        bus_read(10'h020, d);
        chk("R11 status limited to channels", d, 32'h0F);
        bus_read(10'h024, d);
        chk("R11 status high half", d, 32'h0);
        bus_write(10'h020, 32'h5);
        chk("R11 clear written bits", clr, 8'h05);
        irq = 8'h04;
        bus_write(10'h020, 32'hFF);
        chk("R11 clear only pending", clr, 8'h04);
        irq = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capability();
        t_gcfg();
        t_arm();
        t_counter_run();
        t_counter_write();
        t_chan_regs();
        t_out_of_range();
        t_status();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule